// File: doc/BRIEF.md
# Way-Partitioned Cache Replacement Unit

This unit picks replacement victims for a set-associative cache whose ways are split among three requester classes: ordinary instruction/data traffic, multiply lookup tables and add lookup tables. The number of ways a class owns is its partition factor. The factors are written once through a configuration load and stay fixed while the cache runs. A load is accepted only when the factors add up to the associativity.

For each access the unit works out which ways belong to the requesting class. On a miss it returns the least recently used way inside that group, and only that group. A class that owns no ways gets a no-allocate answer. Every hit and every fill moves the touched way to most-recent in a per-set recency order that is shared by all classes. The tag and data arrays, the cache pipeline and coherence sit outside this unit.

Top module: `wp_repl_unit`

## Requirements
- R1: Reset is synchronous and active high. After reset all ways belong to instruction/data, the other two factors are 0, `cfg_err` and `rsp_valid` are 0, and way w of every set has recency rank w, where rank 0 is most recent. The first miss in a set therefore evicts way WAYS-1.
- R2: A configuration load whose three factors sum to exactly WAYS is accepted. The following cycle `cfg_err` is 0 and every later access uses the new factors.
- R3: A configuration load whose factors do not sum to WAYS is rejected. The following cycle `cfg_err` is 1 and the previous factors remain in force.
- R4: Class codes on `acc_class` are 0 for instruction/data, 1 for multiply, 2 for add and 3 for none. The ways are laid out in contiguous ranges starting at way 0: instruction/data first, then multiply, then add. Class 3 owns no ways.
- R5: On a miss whose class owns at least one way, the response has `rsp_alloc`=1 and `rsp_victim` set to the least recently used way of that class's range.
- R6: Every hit, and every miss that allocates, makes the touched way rank 0. Ways that ranked more recent than it move one rank older. All other ranks keep their values.
- R7: A hit returns `rsp_alloc`=0 and `rsp_noalloc`=0 and updates recency even when the hit way lies outside the requester's range. A hit never causes a fill.
- R8: A miss from a class that owns no ways returns `rsp_noalloc`=1 and `rsp_alloc`=0, and leaves recency unchanged.
- R9: Each response is registered. `rsp_valid` is 1 exactly one cycle after a cycle with `acc_valid`=1, and 0 otherwise.
- R10: Recency state is kept per set. An access to one set does not change the order of any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load the partition factors |
| cfg_pf_id | input | CNT_W | Ways requested for instruction/data |
| cfg_pf_mul | input | CNT_W | Ways requested for the multiply tables |
| cfg_pf_add | input | CNT_W | Ways requested for the add tables |
| cfg_err | output | 1 | Last load was rejected |
| acc_valid | input | 1 | Access present this cycle |
| acc_class | input | 2 | Requester class code |
| acc_set | input | SET_W | Set index |
| acc_hit | input | 1 | Lookup hit |
| acc_hit_way | input | WAY_W | Way that hit |
| rsp_valid | output | 1 | Response present |
| rsp_alloc | output | 1 | A victim is returned |
| rsp_noalloc | output | 1 | Miss without allocation |
| rsp_victim | output | WAY_W | Victim way, 0 when no victim is returned |

## Verification
The assertions assume that `acc_class` is a legal two-bit code and that `acc_set` is below SETS. They also assume that a configuration load and an access in the same cycle mean the access sees the factors in force before the load. The bench meets all of these. It runs with four ways and two sets. It sweeps every combination of three-bit factor values, legal and illegal, and after each one it sends a miss and a hit from every class to both sets. Expected victims come from a separate recency model kept in the bench.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    CLS_ID   = 2'd0,
    CLS_MUL  = 2'd1,
    CLS_ADD  = 2'd2,
    CLS_NONE = 2'd3
  } wp_class_e;
endpackage

// File: rtl/wp_cfg.sv
module wp_cfg #(
  parameter int WAYS  = 8,
  parameter int CNT_W = $clog2(WAYS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] ld_id,
  input  logic [CNT_W-1:0] ld_mul,
  input  logic [CNT_W-1:0] ld_add,
  output logic [CNT_W-1:0] pf_id,
  output logic [CNT_W-1:0] pf_mul,
  output logic [CNT_W-1:0] pf_add,
  output logic             err
);
  localparam int SUM_W = CNT_W + 2;
  logic [SUM_W-1:0] sum;
  logic             legal;

  assign sum   = {2'b00, ld_id} + {2'b00, ld_mul} + {2'b00, ld_add};
  assign legal = (sum == SUM_W'(WAYS));

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_id  <= CNT_W'(WAYS);
      pf_mul <= '0;
      pf_add <= '0;
      err    <= 1'b0;
    end else if (load) begin
      err <= !legal;
      if (legal) begin
        pf_id  <= ld_id;
        pf_mul <= ld_mul;
        pf_add <= ld_add;
      end
    end
  end
endmodule

// File: rtl/wp_part_mask.sv
module wp_part_mask
  import wp_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int CNT_W = $clog2(WAYS + 1)
) (
  input  wp_class_e        cls,
  input  logic [CNT_W-1:0] pf_id,
  input  logic [CNT_W-1:0] pf_mul,
  output logic [WAYS-1:0]  mask
);
  localparam int B_W = CNT_W + 1;
  logic [B_W-1:0] lo, hi;

  always_comb begin
    unique case (cls)
      CLS_ID:  begin lo = '0;                             hi = {1'b0, pf_id}; end
      CLS_MUL: begin lo = {1'b0, pf_id};                  hi = {1'b0, pf_id} + {1'b0, pf_mul}; end
      CLS_ADD: begin lo = {1'b0, pf_id} + {1'b0, pf_mul}; hi = B_W'(WAYS); end
      default: begin lo = '0;                             hi = '0; end
    endcase
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic [B_W-1:0] WIDX = B_W'(w);
    assign mask[w] = (WIDX >= lo) && (WIDX < hi);
  end
endmodule

// File: rtl/wp_victim_pick.sv
module wp_victim_pick #(
  parameter int WAYS  = 8,
  parameter int AGE_W = $clog2(WAYS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][AGE_W-1:0] ages,
  input  logic [WAYS-1:0]            mask,
  output logic                       found,
  output logic [WAY_W-1:0]           way
);
  logic [AGE_W-1:0] best;

  always_comb begin
    found = 1'b0;
    way   = '0;
    best  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (mask[w] && (!found || ages[w] > best)) begin
        found = 1'b1;
        way   = WAY_W'(w);
        best  = ages[w];
      end
    end
  end
endmodule

// File: rtl/wp_age_store.sv
module wp_age_store #(
  parameter int WAYS  = 8,
  parameter int SETS  = 16,
  parameter int AGE_W = $clog2(WAYS),
  parameter int WAY_W = $clog2(WAYS),
  parameter int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SET_W-1:0]           set,
  input  logic                       upd_en,
  input  logic [WAY_W-1:0]           upd_way,
  output logic [WAYS-1:0][AGE_W-1:0] cur
);
  logic [WAYS-1:0][AGE_W-1:0] ages_q [SETS];
  logic [WAYS-1:0][AGE_W-1:0] nxt;
  logic [AGE_W-1:0]           tgt;

  assign cur = ages_q[set];

  always_comb begin
    tgt = cur[upd_way];
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == upd_way)  nxt[w] = '0;
      else if (cur[w] < tgt)     nxt[w] = cur[w] + AGE_W'(1);
      else                       nxt[w] = cur[w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          ages_q[s][w] <= AGE_W'(w);
    end else if (upd_en) begin
      ages_q[set] <= nxt;
    end
  end
endmodule

// File: rtl/wp_repl_unit.sv
module wp_repl_unit
  import wp_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int SETS  = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = WAY_W,
  localparam int CNT_W = $clog2(WAYS + 1),
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_pf_id,
  input  logic [CNT_W-1:0] cfg_pf_mul,
  input  logic [CNT_W-1:0] cfg_pf_add,
  output logic             cfg_err,
  input  logic             acc_valid,
  input  logic [1:0]       acc_class,
  input  logic [SET_W-1:0] acc_set,
  input  logic             acc_hit,
  input  logic [WAY_W-1:0] acc_hit_way,
  output logic             rsp_valid,
  output logic             rsp_alloc,
  output logic             rsp_noalloc,
  output logic [WAY_W-1:0] rsp_victim
);
  logic [CNT_W-1:0]           pf_id, pf_mul, pf_add;
  logic [WAYS-1:0]            mask;
  logic [WAYS-1:0][AGE_W-1:0] ages;
  logic                       found;
  logic [WAY_W-1:0]           vic_way;
  logic                       fill, upd_en;
  logic [WAY_W-1:0]           upd_way;

  wp_cfg #(.WAYS(WAYS), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .load(cfg_load),
    .ld_id(cfg_pf_id), .ld_mul(cfg_pf_mul), .ld_add(cfg_pf_add),
    .pf_id(pf_id), .pf_mul(pf_mul), .pf_add(pf_add), .err(cfg_err)
  );

  wp_part_mask #(.WAYS(WAYS), .CNT_W(CNT_W)) u_mask (
    .cls(wp_class_e'(acc_class)), .pf_id(pf_id), .pf_mul(pf_mul), .mask(mask)
  );

  wp_age_store #(.WAYS(WAYS), .SETS(SETS), .AGE_W(AGE_W), .WAY_W(WAY_W), .SET_W(SET_W)) u_age (
    .clk(clk), .rst(rst), .set(acc_set), .upd_en(upd_en), .upd_way(upd_way), .cur(ages)
  );

  wp_victim_pick #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_pick (
    .ages(ages), .mask(mask), .found(found), .way(vic_way)
  );

  assign fill    = acc_valid && !acc_hit && found;
  assign upd_en  = (acc_valid && acc_hit) || fill;
  assign upd_way = acc_hit ? acc_hit_way : vic_way;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_alloc   <= 1'b0;
      rsp_noalloc <= 1'b0;
      rsp_victim  <= '0;
    end else begin
      rsp_valid   <= acc_valid;
      rsp_alloc   <= fill;
      rsp_noalloc <= acc_valid && !acc_hit && !found;
      rsp_victim  <= fill ? vic_way : '0;
    end
  end
endmodule

// File: rtl/wp_repl_chk.sv
module wp_repl_chk #(
  parameter int WAYS  = 8,
  parameter int WAY_W = $clog2(WAYS),
  parameter int CNT_W = $clog2(WAYS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_load,
  input logic [CNT_W-1:0] cfg_pf_id,
  input logic [CNT_W-1:0] cfg_pf_mul,
  input logic [CNT_W-1:0] cfg_pf_add,
  input logic             cfg_err,
  input logic             acc_valid,
  input logic [1:0]       acc_class,
  input logic             acc_hit,
  input logic             rsp_valid,
  input logic             rsp_alloc,
  input logic             rsp_noalloc,
  input logic [WAY_W-1:0] rsp_victim,
  input logic [CNT_W-1:0] pf_id,
  input logic [CNT_W-1:0] pf_mul,
  input logic [CNT_W-1:0] pf_add
);
  function automatic int lo_of(logic [1:0] c, logic [CNT_W-1:0] a, logic [CNT_W-1:0] b);
    case (c)
      2'd1:    return int'(a);
      2'd2:    return int'(a) + int'(b);
      default: return 0;
    endcase
  endfunction

  function automatic int hi_of(logic [1:0] c, logic [CNT_W-1:0] a, logic [CNT_W-1:0] b);
    case (c)
      2'd0:    return int'(a);
      2'd1:    return int'(a) + int'(b);
      2'd2:    return WAYS;
      default: return 0;
    endcase
  endfunction

  function automatic int sz_of(logic [1:0] c, logic [CNT_W-1:0] a, logic [CNT_W-1:0] b,
                               logic [CNT_W-1:0] d);
    case (c)
      2'd0:    return int'(a);
      2'd1:    return int'(b);
      2'd2:    return int'(d);
      default: return 0;
    endcase
  endfunction

  p_factor_sum_r2: assert property (@(posedge clk) disable iff (rst)
    int'(pf_id) + int'(pf_mul) + int'(pf_add) == WAYS);

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_load && (int'(cfg_pf_id) + int'(cfg_pf_mul) + int'(cfg_pf_add) == WAYS)
    |=> !cfg_err && pf_id == $past(cfg_pf_id) && pf_mul == $past(cfg_pf_mul));

  p_reject_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_load && (int'(cfg_pf_id) + int'(cfg_pf_mul) + int'(cfg_pf_add) != WAYS)
    |=> cfg_err && $stable(pf_id) && $stable(pf_mul) && $stable(pf_add));

  p_victim_in_part_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_alloc |->
      int'(rsp_victim) >= lo_of($past(acc_class), $past(pf_id), $past(pf_mul)) &&
      int'(rsp_victim) <  hi_of($past(acc_class), $past(pf_id), $past(pf_mul)));

  p_hit_no_fill_r7: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_hit |=> rsp_valid && !rsp_alloc && !rsp_noalloc);

  p_noalloc_empty_r8: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_hit && sz_of(acc_class, pf_id, pf_mul, pf_add) == 0
    |=> rsp_noalloc && !rsp_alloc);

  p_resp_timing_r9: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !rsp_valid && !rsp_alloc && !rsp_noalloc);

  p_resp_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(rsp_alloc && rsp_noalloc));
endmodule

bind wp_repl_unit wp_repl_chk #(.WAYS(WAYS), .WAY_W(WAY_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_pf_id(cfg_pf_id),
  .cfg_pf_mul(cfg_pf_mul), .cfg_pf_add(cfg_pf_add), .cfg_err(cfg_err),
  .acc_valid(acc_valid), .acc_class(acc_class), .acc_hit(acc_hit),
  .rsp_valid(rsp_valid), .rsp_alloc(rsp_alloc), .rsp_noalloc(rsp_noalloc),
  .rsp_victim(rsp_victim), .pf_id(pf_id), .pf_mul(pf_mul), .pf_add(pf_add)
);

// File: tb/tb_wp_repl_unit.sv
module tb_wp_repl_unit;
  localparam int WAYS = 4;
  localparam int SETS = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_load = 1'b0;
  logic [2:0] cfg_pf_id = '0, cfg_pf_mul = '0, cfg_pf_add = '0;
  logic       cfg_err;
  logic       acc_valid = 1'b0;
  logic [1:0] acc_class = '0;
  logic [0:0] acc_set = '0;
  logic       acc_hit = 1'b0;
  logic [1:0] acc_hit_way = '0;
  logic       rsp_valid, rsp_alloc, rsp_noalloc;
  logic [1:0] rsp_victim;

  wp_repl_unit #(.WAYS(WAYS), .SETS(SETS)) dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_pf_id(cfg_pf_id),
    .cfg_pf_mul(cfg_pf_mul), .cfg_pf_add(cfg_pf_add), .cfg_err(cfg_err),
    .acc_valid(acc_valid), .acc_class(acc_class), .acc_set(acc_set),
    .acc_hit(acc_hit), .acc_hit_way(acc_hit_way), .rsp_valid(rsp_valid),
    .rsp_alloc(rsp_alloc), .rsp_noalloc(rsp_noalloc), .rsp_victim(rsp_victim)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int m_age [SETS][WAYS];
  int m_pf  [3];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lo_of(int c);
    case (c)
      1: return m_pf[0];
      2: return m_pf[0] + m_pf[1];
      default: return 0;
    endcase
  endfunction

  function automatic int hi_of(int c);
    case (c)
      0: return m_pf[0];
      1: return m_pf[0] + m_pf[1];
      2: return WAYS;
      default: return 0;
    endcase
  endfunction

  task automatic touch(input int s, input int w);
    int t;
    t = m_age[s][w];
    for (int i = 0; i < WAYS; i++) begin
      if (i == w) m_age[s][i] = 0;
      else if (m_age[s][i] < t) m_age[s][i]++;
    end
  endtask

  task automatic do_load(input int a, input int b, input int c);
    cfg_load = 1'b1; cfg_pf_id = 3'(a); cfg_pf_mul = 3'(b); cfg_pf_add = 3'(c);
    @(posedge clk); #1;
    cfg_load = 1'b0;
    if (a + b + c == WAYS) begin
      m_pf[0] = a; m_pf[1] = b; m_pf[2] = c;
      chk(cfg_err == 1'b0, "R2 accept", int'(cfg_err), 0);
    end else begin
      chk(cfg_err == 1'b1, "R3 reject", int'(cfg_err), 1);
    end
    chk(rsp_valid == 1'b0, "R9 idle", int'(rsp_valid), 0);
  endtask

  task automatic do_acc(input int c, input int s, input bit hit, input int hw);
    int exp_v, best;
    bit exp_a;
    exp_a = 1'b0; exp_v = 0; best = -1;
    if (!hit) begin
      for (int w = lo_of(c); w < hi_of(c); w++)
        if (m_age[s][w] > best) begin best = m_age[s][w]; exp_v = w; exp_a = 1'b1; end
    end
    acc_valid = 1'b1; acc_class = 2'(c); acc_set = 1'(s); acc_hit = hit; acc_hit_way = 2'(hw);
    @(posedge clk); #1;
    acc_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R9 valid", int'(rsp_valid), 1);
    if (hit) begin
      chk(!rsp_alloc && !rsp_noalloc, "R7 hit", {rsp_alloc, rsp_noalloc}, 0);
      touch(s, hw);
    end else if (exp_a) begin
      chk(rsp_alloc && !rsp_noalloc, "R5 alloc", {rsp_alloc, rsp_noalloc}, 2);
      chk(int'(rsp_victim) == exp_v, "R4 R5 R6 R10 victim", int'(rsp_victim), exp_v);
      touch(s, exp_v);
    end else begin
      chk(!rsp_alloc && rsp_noalloc, "R8 noalloc", {rsp_alloc, rsp_noalloc}, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) m_age[s][w] = w;
    m_pf[0] = WAYS; m_pf[1] = 0; m_pf[2] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R1 reset valid", int'(rsp_valid), 0);
    chk(cfg_err == 1'b0, "R1 reset err", int'(cfg_err), 0);
    rst = 1'b0;
    do_acc(0, 0, 1'b0, 0);   // R1: first victim is way WAYS-1
    do_acc(1, 1, 1'b0, 0);   // R8: multiply owns nothing after reset
    do_acc(0, 1, 1'b0, 0);   // R10: set 1 untouched by set 0 traffic
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 8; c++) begin
          do_load(a, b, c);
          for (int s = 0; s < SETS; s++)
            for (int k = 0; k < 4; k++) begin
              do_acc(k, s, 1'b0, 0);
              do_acc(k, s, 1'b1, (a + b + c + s + k) % WAYS);
            end
        end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule